// File: doc/BRIEF.md
# Slowdown-Balancing Fairness Arbiter

This block sits ahead of a DRAM request picker that serves several hardware threads. For every thread it receives two stall-time figures: the stall time measured while sharing memory, and an estimate of the stall time the thread would see alone. The ratio of the two is the thread's slowdown. Among the threads that currently hold at least one valid request, the block finds the most and the least slowed thread, and takes the quotient of their slowdowns as the unfairness of the system.

When unfairness stays below a programmable threshold (unsigned fixed point with FRAC fraction bits, 8.8 by default), the block runs in throughput mode: the picker favours row hits, then older requests. At or above the threshold it runs in fairness mode, and requests from the most slowed thread rank above all others, then row hits, then age. All ratio comparisons are done by cross-multiplication, so no divider is needed. The picker grants the slot with the largest key. The decision is recomputed every cycle and presented one clock after its inputs.

Top module: `slowdown_fair_arbiter`

## Requirements
- R1: While rst_n is low and in the first cycle after it, fair_mode, fav_thread and every req_key are zero.
- R2: A thread's slowdown is shared stall divided by alone stall; a thread whose alone stall is zero counts as slowdown exactly 1.
- R3: Only threads named by at least one slot with req_valid set take part in the max and min search; stall values of other threads have no effect.
- R4: With fewer than two participating threads, fair_mode is 0.
- R5: With two or more participating threads, fair_mode is 1 when max slowdown / min slowdown >= alpha / 2^FRAC, and 0 when it is below.
- R6: A valid slot's key is {fav bit [5], row-hit bit [4], bitwise-inverted age [3:0]}; in throughput mode the fav bit is 0.
- R7: In fairness mode the fav bit of a valid slot is 1 exactly when its req_thread equals fav_thread.
- R8: fav_thread is the participating thread with the largest slowdown, the lowest index winning a tie; it is 0 when no thread participates.
- R9: A slot with req_valid low has key 0.
- R10: Outputs are registered: a change on the inputs shows on the outputs after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shared_stall | input | NUM_THREADS*ST_W | Per-thread stall time while sharing, thread 0 in the low bits |
| alone_stall | input | NUM_THREADS*ST_W | Per-thread estimated stall time alone |
| alpha | input | ALPHA_W | Unfairness threshold, FRAC fraction bits |
| req_valid | input | NUM_REQ | Slot holds a request |
| req_thread | input | NUM_REQ*TID_W | Owning thread per slot |
| req_row_hit | input | NUM_REQ | Slot targets the open row |
| req_age | input | NUM_REQ*AGE_W | Arrival stamp per slot, smaller is older |
| fair_mode | output | 1 | 1 = fairness ordering in force |
| fav_thread | output | TID_W | Most slowed participating thread |
| req_key | output | NUM_REQ*KEY_W | Priority key per slot, largest wins |

## Verification
Equal slowdowns across all threads separate the two modes from a design that always favours somebody, and a single strongly slowed thread shows the mode switch and the favoured bit landing on the right slots. Unfairness set exactly on the threshold and one step above it pins down the inclusive comparison, while a heavily slowed thread with no valid slot, a lone participating thread, and a zero alone estimate that would otherwise dominate each expose a different way of mis-selecting the extremes. Two threads tied at the maximum show which index wins, and holding the inputs before a clock edge shows the output register stage.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
  typedef enum logic {
    MODE_THRU = 1'b0,
    MODE_FAIR = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/fsa_slowdown_norm.sv
module fsa_slowdown_norm #(
  parameter int NUM_THREADS = 4,
  parameter int ST_W        = 16
) (
  input  logic [NUM_THREADS*ST_W-1:0] shared_flat,
  input  logic [NUM_THREADS*ST_W-1:0] alone_flat,
  output logic [NUM_THREADS*ST_W-1:0] num_flat,
  output logic [NUM_THREADS*ST_W-1:0] den_flat
);
  localparam logic [ST_W-1:0] ONE = ST_W'(1);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [ST_W-1:0] sh, al;
    logic            zero_alone;
    assign sh         = shared_flat[t*ST_W +: ST_W];
    assign al         = alone_flat[t*ST_W +: ST_W];
    assign zero_alone = (al == '0);
    // unknown standalone time: present the ratio 1/1
    assign num_flat[t*ST_W +: ST_W] = zero_alone ? ONE : sh;
    assign den_flat[t*ST_W +: ST_W] = zero_alone ? ONE : al;
  end
endmodule

// File: rtl/fsa_extreme_finder.sv
module fsa_extreme_finder #(
  parameter int NUM_THREADS = 4,
  parameter int ST_W        = 16,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS*ST_W-1:0] num_flat,
  input  logic [NUM_THREADS*ST_W-1:0] den_flat,
  input  logic [NUM_THREADS-1:0]      active,
  output logic [TID_W-1:0]            max_idx,
  output logic [TID_W-1:0]            min_idx
);
  localparam int PW = 2*ST_W;

  // a_n/a_d > b_n/b_d without a divider
  function automatic logic ratio_gt(input logic [ST_W-1:0] a_n, input logic [ST_W-1:0] a_d,
                                    input logic [ST_W-1:0] b_n, input logic [ST_W-1:0] b_d);
    logic [PW-1:0] lhs, rhs;
    lhs = {{ST_W{1'b0}}, a_n} * {{ST_W{1'b0}}, b_d};
    rhs = {{ST_W{1'b0}}, b_n} * {{ST_W{1'b0}}, a_d};
    return lhs > rhs;
  endfunction

  always_comb begin
    logic            found;
    logic [ST_W-1:0] mx_n, mx_d, mn_n, mn_d, cn, cd;
    found   = 1'b0;
    max_idx = '0;
    min_idx = '0;
    mx_n = '0; mx_d = '0; mn_n = '0; mn_d = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      cn = num_flat[i*ST_W +: ST_W];
      cd = den_flat[i*ST_W +: ST_W];
      if (active[i]) begin
        if (!found || ratio_gt(cn, cd, mx_n, mx_d)) begin
          max_idx = TID_W'(i);
          mx_n = cn; mx_d = cd;
        end
        if (!found || ratio_gt(mn_n, mn_d, cn, cd)) begin
          min_idx = TID_W'(i);
          mn_n = cn; mn_d = cd;
        end
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsa_mode_decide.sv
module fsa_mode_decide
  import fsa_pkg::*;
#(
  parameter int ST_W    = 16,
  parameter int ALPHA_W = 16,
  parameter int FRAC    = 8
) (
  input  logic [ST_W-1:0]    max_num,
  input  logic [ST_W-1:0]    max_den,
  input  logic [ST_W-1:0]    min_num,
  input  logic [ST_W-1:0]    min_den,
  input  logic [ALPHA_W-1:0] alpha,
  input  logic               multi,
  output arb_mode_e          mode
);
  localparam int CW = 2*ST_W + ALPHA_W + FRAC;

  // (max_num/max_den) / (min_num/min_den) >= alpha / 2^FRAC
  function automatic logic unfair_at_least(input logic [ST_W-1:0] xn, input logic [ST_W-1:0] xd,
                                           input logic [ST_W-1:0] nn, input logic [ST_W-1:0] nd,
                                           input logic [ALPHA_W-1:0] a);
    logic [CW-1:0] lhs, rhs;
    lhs = (CW'(xn) * CW'(nd)) << FRAC;
    rhs = CW'(a) * CW'(xd) * CW'(nn);
    return lhs >= rhs;
  endfunction

  always_comb begin
    if (multi && unfair_at_least(max_num, max_den, min_num, min_den, alpha)) mode = MODE_FAIR;
    else                                                                     mode = MODE_THRU;
  end
endmodule

// File: rtl/fsa_key_gen.sv
module fsa_key_gen
  import fsa_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int TID_W   = 2,
  parameter int AGE_W   = 4,
  localparam int KEY_W  = AGE_W + 2
) (
  input  logic [NUM_REQ-1:0]       valid,
  input  logic [NUM_REQ*TID_W-1:0] tid_flat,
  input  logic [NUM_REQ-1:0]       row_hit,
  input  logic [NUM_REQ*AGE_W-1:0] age_flat,
  input  arb_mode_e                mode,
  input  logic [TID_W-1:0]         fav,
  output logic [NUM_REQ*KEY_W-1:0] key_flat
);
  for (genvar s = 0; s < NUM_REQ; s++) begin : g_slot
    logic boost;
    assign boost = (mode == MODE_FAIR) && (tid_flat[s*TID_W +: TID_W] == fav);
    assign key_flat[s*KEY_W +: KEY_W] = valid[s]
        ? {boost, row_hit[s], ~age_flat[s*AGE_W +: AGE_W]}
        : '0;
  end
endmodule

// File: rtl/slowdown_fair_arbiter.sv
module slowdown_fair_arbiter
  import fsa_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int ST_W        = 16,
  parameter int ALPHA_W     = 16,
  parameter int FRAC        = 8,
  parameter int NUM_REQ     = 8,
  parameter int AGE_W       = 4,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int KEY_W      = AGE_W + 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_THREADS*ST_W-1:0]   shared_stall,
  input  logic [NUM_THREADS*ST_W-1:0]   alone_stall,
  input  logic [ALPHA_W-1:0]            alpha,
  input  logic [NUM_REQ-1:0]            req_valid,
  input  logic [NUM_REQ*TID_W-1:0]      req_thread,
  input  logic [NUM_REQ-1:0]            req_row_hit,
  input  logic [NUM_REQ*AGE_W-1:0]      req_age,
  output logic                          fair_mode,
  output logic [TID_W-1:0]              fav_thread,
  output logic [NUM_REQ*KEY_W-1:0]      req_key
);
  logic [NUM_THREADS*ST_W-1:0] num_flat, den_flat;
  logic [NUM_THREADS-1:0]      thr_active;
  logic [TID_W-1:0]            max_idx, min_idx;
  logic                        multi_active;
  arb_mode_e                   mode_now;
  logic [NUM_REQ*KEY_W-1:0]    key_now;

  // which threads own at least one valid slot
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_act
    logic [NUM_REQ-1:0] hit_vec;
    for (genvar s = 0; s < NUM_REQ; s++) begin : g_s
      assign hit_vec[s] = req_valid[s] && (req_thread[s*TID_W +: TID_W] == TID_W'(t));
    end
    assign thr_active[t] = |hit_vec;
  end

  always_comb begin
    int cnt;
    cnt = 0;
    for (int t = 0; t < NUM_THREADS; t++) cnt += int'(thr_active[t]);
    multi_active = (cnt >= 2);
  end

  fsa_slowdown_norm #(.NUM_THREADS(NUM_THREADS), .ST_W(ST_W)) u_norm (
    .shared_flat(shared_stall), .alone_flat(alone_stall),
    .num_flat(num_flat), .den_flat(den_flat)
  );

  fsa_extreme_finder #(.NUM_THREADS(NUM_THREADS), .ST_W(ST_W), .TID_W(TID_W)) u_find (
    .num_flat(num_flat), .den_flat(den_flat), .active(thr_active),
    .max_idx(max_idx), .min_idx(min_idx)
  );

  fsa_mode_decide #(.ST_W(ST_W), .ALPHA_W(ALPHA_W), .FRAC(FRAC)) u_mode (
    .max_num(num_flat[max_idx*ST_W +: ST_W]), .max_den(den_flat[max_idx*ST_W +: ST_W]),
    .min_num(num_flat[min_idx*ST_W +: ST_W]), .min_den(den_flat[min_idx*ST_W +: ST_W]),
    .alpha(alpha), .multi(multi_active), .mode(mode_now)
  );

  fsa_key_gen #(.NUM_REQ(NUM_REQ), .TID_W(TID_W), .AGE_W(AGE_W)) u_keys (
    .valid(req_valid), .tid_flat(req_thread), .row_hit(req_row_hit), .age_flat(req_age),
    .mode(mode_now), .fav(max_idx), .key_flat(key_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fair_mode  <= 1'b0;
      fav_thread <= '0;
      req_key    <= '0;
    end else begin
      fair_mode  <= (mode_now == MODE_FAIR);
      fav_thread <= max_idx;
      req_key    <= key_now;
    end
  end
endmodule

// File: rtl/fsa_arbiter_chk.sv
module fsa_arbiter_chk #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_REQ     = 8,
  parameter int TID_W       = 2,
  parameter int KEY_W       = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_REQ-1:0]       req_valid,
  input logic [NUM_THREADS-1:0]   thr_active,
  input logic [TID_W-1:0]         max_idx,
  input logic [TID_W-1:0]         min_idx,
  input logic                     fair_mode,
  input logic [NUM_REQ*KEY_W-1:0] req_key
);
  logic [NUM_REQ-1:0] fav_bits;
  for (genvar s = 0; s < NUM_REQ; s++) begin : g_s
    assign fav_bits[s] = req_key[s*KEY_W + KEY_W - 1];

    assert_idle_slot_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid[s] |=> (req_key[s*KEY_W +: KEY_W] == '0));
  end

  assert_lone_thread_thru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(thr_active) < 2) |=> !fair_mode);

  assert_thru_no_favour_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fair_mode |-> (fav_bits == '0));

  assert_max_is_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|thr_active) |-> thr_active[max_idx]);

  assert_min_is_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|thr_active) |-> thr_active[min_idx]);
endmodule

bind slowdown_fair_arbiter fsa_arbiter_chk #(
  .NUM_THREADS(NUM_THREADS), .NUM_REQ(NUM_REQ), .TID_W(TID_W), .KEY_W(KEY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .thr_active(thr_active),
  .max_idx(max_idx), .min_idx(min_idx), .fair_mode(fair_mode), .req_key(req_key)
);

// File: tb/sim_slowdown_fair_arbiter.sv
module sim_slowdown_fair_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4, SW = 16, AW = 16, FR = 8, NR = 8, GW = 4, TW = 2, KW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT*SW-1:0] shared_stall = '0, alone_stall = '0;
  logic [AW-1:0]    alpha = '0;
  logic [NR-1:0]    req_valid = '0, req_row_hit = '0;
  logic [NR*TW-1:0] req_thread = '0;
  logic [NR*GW-1:0] req_age = '0;
  logic             fair_mode;
  logic [TW-1:0]    fav_thread;
  logic [NR*KW-1:0] req_key;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slowdown_fair_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .shared_stall(shared_stall), .alone_stall(alone_stall),
    .alpha(alpha), .req_valid(req_valid), .req_thread(req_thread), .req_row_hit(req_row_hit),
    .req_age(req_age), .fair_mode(fair_mode), .fav_thread(fav_thread), .req_key(req_key)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_thr(input int t, input int sh, input int al);
    shared_stall[t*SW +: SW] = SW'(sh);
    alone_stall[t*SW +: SW]  = SW'(al);
  endtask

  task automatic set_slot(input int s, input bit v, input int t, input bit h, input int a);
    req_valid[s] = v;
    req_thread[s*TW +: TW] = TW'(t);
    req_row_hit[s] = h;
    req_age[s*GW +: GW] = GW'(a);
  endtask

  // independent model using real-valued ratios
  task automatic expect_now(output bit e_fair, output int e_fav, output logic [NR*KW-1:0] e_key);
    real sd[NT];
    bit  act[NT];
    int  cnt, mx, mn;
    cnt = 0; mx = -1; mn = -1;
    for (int t = 0; t < NT; t++) begin
      int al = int'(alone_stall[t*SW +: SW]);
      sd[t] = (al == 0) ? 1.0 : real'(int'(shared_stall[t*SW +: SW])) / real'(al);
      act[t] = 0;
    end
    for (int s = 0; s < NR; s++) if (req_valid[s]) act[int'(req_thread[s*TW +: TW])] = 1;
    for (int t = 0; t < NT; t++) if (act[t]) begin
      cnt++;
      if (mx < 0 || sd[t] > sd[mx]) mx = t;
      if (mn < 0 || sd[t] < sd[mn]) mn = t;
    end
    e_fav  = (mx < 0) ? 0 : mx;
    e_fair = (cnt >= 2) && (sd[mx] / sd[mn] >= real'(int'(alpha)) / 256.0);
    for (int s = 0; s < NR; s++) begin
      logic [KW-1:0] k;
      if (!req_valid[s]) k = '0;
      else k = {e_fair && (int'(req_thread[s*TW +: TW]) == e_fav), req_row_hit[s],
                ~req_age[s*GW +: GW]};
      e_key[s*KW +: KW] = k;
    end
  endtask

  // clock the current inputs in and compare outputs one edge later
  task automatic apply_and_check(input string mreq);
    bit e_fair; int e_fav; logic [NR*KW-1:0] e_key;
    expect_now(e_fair, e_fav, e_key);
    @(posedge clk); #1;
    chk(mreq, "fair_mode", fair_mode, e_fair);
    chk("R8", "fav_thread", fav_thread, e_fav);
    for (int s = 0; s < NR; s++)
      chk(req_valid[s] ? (e_fair ? "R7" : "R6") : "R9", $sformatf("key[%0d]", s),
          req_key[s*KW +: KW], e_key[s*KW +: KW]);
  endtask

  task automatic base_slots();
    for (int s = 0; s < NR; s++) set_slot(s, 1, s % NT, s[0], s);
  endtask

  task automatic t_reset();
    rst_n = 0;
    base_slots();
    for (int t = 0; t < NT; t++) set_thr(t, 100, 10);
    set_thr(2, 900, 10);
    alpha = 16'd256;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "fair_mode in reset", fair_mode, 0);
    chk("R1", "fav_thread in reset", fav_thread, 0);
    chk("R1", "req_key in reset", req_key, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_equal();
    @(negedge clk);
    base_slots();
    for (int t = 0; t < NT; t++) set_thr(t, 200, 100);
    alpha = 16'd384;
    apply_and_check("R5");
  endtask

  task automatic t_one_slow();
    @(negedge clk);
    base_slots();
    req_valid[1] = 0;
    for (int t = 0; t < NT; t++) set_thr(t, 100, 100);
    set_thr(2, 400, 100);
    alpha = 16'd384;
    apply_and_check("R5");
    chk("R7", "fav is thread 2", fav_thread, 2);
  endtask

  task automatic t_boundary();
    @(negedge clk);
    base_slots();
    for (int t = 0; t < NT; t++) set_thr(t, 64, 64);
    set_thr(3, 128, 64);
    alpha = 16'd512;
    apply_and_check("R5");
    chk("R5", "ratio equal to alpha", fair_mode, 1);
    @(negedge clk);
    alpha = 16'd513;
    apply_and_check("R5");
    chk("R5", "ratio just below alpha", fair_mode, 0);
  endtask

  task automatic t_single();
    @(negedge clk);
    for (int s = 0; s < NR; s++) set_slot(s, s < 3, 1, s[0], 5 + s);
    for (int t = 0; t < NT; t++) set_thr(t, 10, 100);
    set_thr(1, 5000, 10);
    alpha = 16'd256;
    apply_and_check("R4");
    chk("R4", "lone thread stays thru", fair_mode, 0);
  endtask

  task automatic t_inactive();
    @(negedge clk);
    for (int s = 0; s < NR; s++) set_slot(s, s < 4, s % 2, 1'b1, 15 - s);
    set_thr(0, 300, 100); set_thr(1, 300, 100);
    set_thr(2, 100, 100); set_thr(3, 9000, 10);
    alpha = 16'd320;
    apply_and_check("R3");
    chk("R3", "idle threads ignored", fair_mode, 0);
  endtask

  task automatic t_zero_alone();
    @(negedge clk);
    for (int s = 0; s < NR; s++) set_slot(s, s < 6, s % 2, s[1], s);
    set_thr(0, 150, 100); set_thr(1, 5000, 0);
    set_thr(2, 1, 1); set_thr(3, 1, 1);
    alpha = 16'd320;
    apply_and_check("R2");
    chk("R2", "zero-alone thread not favoured", fav_thread, 0);
    chk("R2", "ratio 1.5 vs 1", fair_mode, 1);
  endtask

  task automatic t_tie();
    @(negedge clk);
    base_slots();
    set_thr(0, 100, 100); set_thr(1, 300, 100);
    set_thr(2, 100, 100); set_thr(3, 600, 200);
    alpha = 16'd512;
    apply_and_check("R8");
    chk("R8", "tie picks lower index", fav_thread, 1);
  endtask

  task automatic t_none();
    @(negedge clk);
    req_valid = '0;
    apply_and_check("R9");
    chk("R9", "all keys zero", req_key, 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    base_slots();
    for (int t = 0; t < NT; t++) set_thr(t, 100, 100);
    alpha = 16'd384;
    @(posedge clk); #1;
    chk("R10", "thru before change", fair_mode, 0);
    @(negedge clk);
    set_thr(0, 800, 100);
    #1;
    chk("R10", "held before edge", fair_mode, 0);
    apply_and_check("R10");
    chk("R10", "updated after edge", fair_mode, 1);
  endtask

  initial begin
    t_reset();
    t_equal();
    t_one_slow();
    t_boundary();
    t_single();
    t_inactive();
    t_zero_alone();
    t_tie();
    t_none();
    t_latency();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule